// File: doc/BRIEF.md
# Unlock Sequence Command Detector

This block sits beside a byte-wide memory array and watches each completed access to it. When software reads five fixed addresses in a fixed order and then reads one of two closing addresses, the block issues a single command pulse. One closing address asks for the array contents to be saved to the nonvolatile copy (save command). The other asks for them to be reloaded from that copy (reload command). Any access that breaks the order cancels the attempt, so ordinary traffic can never fire a command by accident.

Each access arrives as a one-cycle strobe with a read/write flag and an address. While the array is held off by a running save or reload, strobes are disregarded. The command outputs are registered and last one clock cycle. The first five reads of the sequence are ordinary reads that return data. Disabling the array for the sixth read is the job of the logic that consumes the pulse.

Top module: `unlock_seq_detector`

## Requirements
- R1: A read of 0x0000, then 0x1555, 0x0AAA, 0x1FFF and 0x10F0 in that order, followed by a read of 0x0F0F, raises `save_pulse`.
- R2: The same five reads followed by a read of 0x0F0E raise `reload_pulse`. The two pulses are never high together.
- R3: A write access (`acc_write` = 1) at any point in the sequence cancels it. A write never counts as a step.
- R4: A read of any address other than the expected next one cancels the sequence and issues no command. This includes a wrong sixth address.
- R5: Each pulse is high for exactly one clock cycle. It is seen in the cycle after the clock edge that accepts the sixth read.
- R6: A cancelling read whose address is 0x0000 counts as the first step of a new attempt, so matching resumes at the second step.
- R7: An access presented while `array_busy` = 1 is ignored. It neither advances nor cancels the sequence.
- R8: After a command is issued, the detector returns to its idle state. A further command needs all six reads again.
- R9: While `rst_n` = 0 at a clock edge, the detector goes idle and both pulses are low.
- R10: Cycles with `acc_valid` = 0 leave the progress of the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | One-cycle strobe marking a completed access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 13 | Byte address of the access |
| array_busy | input | 1 | Array disabled by a running save or reload |
| save_pulse | output | 1 | One-cycle save command |
| reload_pulse | output | 1 | One-cycle reload command |

## Verification
The detector is driven with the exact save and reload sequences, with idle gaps between some steps. This separates the two closing addresses and shows that gaps are harmless. Sequences broken by a write, by a stray read, by a wrong closing read, or made entirely of writes are expected to produce no pulse. Each of these is followed by a clean sequence, which shows that the cancel really returned the detector to idle. A sequence with a repeated 0x0000 in the middle shows resumption at the second step rather than at idle. Busy-time reads and writes dropped into the middle of a sequence are expected to leave it intact. A lone closing read straight after a command is expected not to fire again.

// File: rtl/unlock_seq_pkg.sv
// Package: shared widths and the fixed unlock address pattern.
// Assumes a 13-bit byte address space; the pattern is computed by a function.
package unlock_seq_pkg;
    localparam int ADDR_W     = 13;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    localparam logic [ADDR_W-1:0] SAVE_ADDR   = 13'h0F0F;
    localparam logic [ADDR_W-1:0] RELOAD_ADDR = 13'h0F0E;

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_SAVE   = 2'b01,
        CMD_RELOAD = 2'b10
    } cmd_e;

    // Expected address for prefix position idx (0 = first read).
    function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
        case (idx)
            0:       prefix_addr = 13'h0000;
            1:       prefix_addr = 13'h1555;
            2:       prefix_addr = 13'h0AAA;
            3:       prefix_addr = 13'h1FFF;
            4:       prefix_addr = 13'h10F0;
            default: prefix_addr = '1;
        endcase
    endfunction
endpackage

// File: rtl/unlock_addr_match.sv
// Module: compares one access address against every prefix position and
// against both closing addresses. Purely combinational; assumes the
// address is stable for the cycle the strobe is high.
module unlock_addr_match
    import unlock_seq_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    output logic [PREFIX_LEN-1:0] prefix_hit,
    output logic                  is_save,
    output logic                  is_reload,
    output logic                  is_start
);
    // One comparator per prefix position.
    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
        assign prefix_hit[g] = (addr == prefix_addr(g));
    end

    // Closing-address and restart decodes.
    assign is_save   = (addr == SAVE_ADDR);
    assign is_reload = (addr == RELOAD_ADDR);
    assign is_start  = prefix_hit[0];
endmodule

// File: rtl/unlock_seq_fsm.sv
// Module: tracks progress through the unlock pattern and decides when a
// command fires. The step register counts matched prefix reads; the value
// PREFIX_LEN means the detector is waiting for the closing read.
// Assumes at most one access strobe per cycle.
module unlock_seq_fsm
    import unlock_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic                  array_busy,
    input  logic [PREFIX_LEN-1:0] prefix_hit,
    input  logic                  is_save,
    input  logic                  is_reload,
    input  logic                  is_start,
    output cmd_e                  cmd_fire
);
    localparam step_t LAST_STEP = step_t'(PREFIX_LEN);

    step_t step_q, step_d;
    logic  take, take_rd, take_wr, exp_hit;

    // Qualify the strobe with the busy gate.
    assign take    = acc_valid && !array_busy;
    assign take_rd = take && !acc_write;
    assign take_wr = take && acc_write;

    // Select the comparator for the current position.
    always_comb begin
        exp_hit = 1'b0;
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (step_q == step_t'(i)) exp_hit = prefix_hit[i];
        end
    end

    // Next-step and command decision.
    always_comb begin
        step_d   = step_q;
        cmd_fire = CMD_NONE;
        if (take_wr) begin
            step_d = '0;
        end else if (take_rd) begin
            if (step_q != LAST_STEP && exp_hit) begin
                step_d = step_q + step_t'(1);
            end else if (step_q == LAST_STEP && is_save) begin
                step_d   = '0;
                cmd_fire = CMD_SAVE;
            end else if (step_q == LAST_STEP && is_reload) begin
                step_d   = '0;
                cmd_fire = CMD_RELOAD;
            end else begin
                step_d = is_start ? step_t'(1) : '0;
            end
        end
    end

    // Step register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end
endmodule

// File: rtl/unlock_cmd_pulse.sv
// Module: registers the command decision into two one-cycle pulses.
// Assumes the decision input is high for a single cycle per command.
module unlock_cmd_pulse
    import unlock_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd_fire,
    output logic save_pulse,
    output logic reload_pulse
);
    // Output registers, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_pulse   <= 1'b0;
            reload_pulse <= 1'b0;
        end else begin
            save_pulse   <= (cmd_fire == CMD_SAVE);
            reload_pulse <= (cmd_fire == CMD_RELOAD);
        end
    end
endmodule

// File: rtl/unlock_seq_detector.sv
// Top: detects the six-read unlock pattern on the access stream and emits
// save or reload command pulses. Assumes access strobes are already
// synchronous to clk and that array_busy is driven by the command consumer.
module unlock_seq_detector
    import unlock_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              array_busy,
    output logic              save_pulse,
    output logic              reload_pulse
);
    logic [PREFIX_LEN-1:0] prefix_hit;
    logic                  is_save, is_reload, is_start;
    cmd_e                  cmd_fire;

    unlock_addr_match u_match (
        .addr       (acc_addr),
        .prefix_hit (prefix_hit),
        .is_save    (is_save),
        .is_reload  (is_reload),
        .is_start   (is_start)
    );

    unlock_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .array_busy (array_busy),
        .prefix_hit (prefix_hit),
        .is_save    (is_save),
        .is_reload  (is_reload),
        .is_start   (is_start),
        .cmd_fire   (cmd_fire)
    );

    unlock_cmd_pulse u_pulse (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_fire     (cmd_fire),
        .save_pulse   (save_pulse),
        .reload_pulse (reload_pulse)
    );
endmodule

// File: rtl/unlock_seq_checker.sv
// Checker: temporal properties on the detector ports, bound to the top.
module unlock_seq_checker
    import unlock_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              array_busy,
    input logic              save_pulse,
    input logic              reload_pulse
);
    a_r1_save_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
        save_pulse |-> $past(acc_valid && !acc_write && !array_busy && acc_addr == SAVE_ADDR));

    a_r2_reload_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> $past(acc_valid && !acc_write && !array_busy && acc_addr == RELOAD_ADDR));

    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(save_pulse && reload_pulse));

    a_r3_write_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> !save_pulse && !reload_pulse);

    a_r5_save_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        save_pulse |=> !save_pulse);

    a_r5_reload_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |=> !reload_pulse);

    a_r7_busy_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        array_busy |=> !save_pulse && !reload_pulse);

    a_r10_idle_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !save_pulse && !reload_pulse);
endmodule

bind unlock_seq_detector unlock_seq_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .array_busy   (array_busy),
    .save_pulse   (save_pulse),
    .reload_pulse (reload_pulse)
);

// File: tb/tb_unlock_seq_detector.sv
module tb_unlock_seq_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [12:0] acc_addr = '0;
    logic        array_busy = 1'b0;
    logic        save_pulse, reload_pulse;

    int checks = 0;
    int failures = 0;
    int n_save = 0;
    int n_reload = 0;

    always #5 clk = ~clk;

    unlock_seq_detector dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .array_busy(array_busy),
        .save_pulse(save_pulse), .reload_pulse(reload_pulse)
    );

    // Pulse counters sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && save_pulse)   n_save++;
        if (rst_n && reload_pulse) n_reload++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One access; returns at the falling edge after the accepting edge.
    task automatic access(input logic w, input logic [12:0] a, input logic b);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; array_busy = b;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; array_busy = 1'b0;
    endtask

    task automatic prefix();
        access(0, 13'h0000, 0); access(0, 13'h1555, 0); access(0, 13'h0AAA, 0);
        access(0, 13'h1FFF, 0); access(0, 13'h10F0, 0);
    endtask

    task automatic counts(input string req, input int s, input int r);
        @(negedge clk); @(negedge clk);
        check({req, " save count"}, n_save, s);
        check({req, " reload count"}, n_reload, r);
        n_save = 0; n_reload = 0;
    endtask

    task automatic t_reset();
        check("R9 save low", save_pulse, 0);
        check("R9 reload low", reload_pulse, 0);
    endtask

    task automatic t_save();
        prefix();
        access(0, 13'h0F0F, 0);
        check("R1 save high", save_pulse, 1);
        check("R2 reload low on save", reload_pulse, 0);
        @(negedge clk);
        check("R5 save one cycle", save_pulse, 0);
        counts("R1", 1, 0);
    endtask

    task automatic t_reload_gaps();
        access(0, 13'h0000, 0); repeat (3) @(negedge clk);
        access(0, 13'h1555, 0); access(0, 13'h0AAA, 0); @(negedge clk);
        access(0, 13'h1FFF, 0); access(0, 13'h10F0, 0); repeat (2) @(negedge clk);
        access(0, 13'h0F0E, 0);
        check("R2 reload high", reload_pulse, 1);
        check("R10 gaps kept progress", reload_pulse, 1);
        @(negedge clk);
        check("R5 reload one cycle", reload_pulse, 0);
        counts("R2", 0, 1);
    endtask

    task automatic t_write_abort();
        access(0, 13'h0000, 0); access(0, 13'h1555, 0); access(0, 13'h0AAA, 0);
        access(1, 13'h1FFF, 0);
        access(0, 13'h1FFF, 0); access(0, 13'h10F0, 0); access(0, 13'h0F0F, 0);
        counts("R3 write abort", 0, 0);
        access(1, 13'h0000, 0); access(1, 13'h1555, 0); access(1, 13'h0AAA, 0);
        access(1, 13'h1FFF, 0); access(1, 13'h10F0, 0); access(1, 13'h0F0F, 0);
        counts("R3 writes only", 0, 0);
        prefix(); access(0, 13'h0F0E, 0);
        counts("R3 clean after abort", 0, 1);
    endtask

    task automatic t_stray_read();
        access(0, 13'h0000, 0); access(0, 13'h1555, 0); access(0, 13'h0123, 0);
        access(0, 13'h0AAA, 0); access(0, 13'h1FFF, 0); access(0, 13'h10F0, 0);
        access(0, 13'h0F0F, 0);
        counts("R4 stray read", 0, 0);
        prefix(); access(0, 13'h0F0D, 0); access(0, 13'h0F0F, 0);
        counts("R4 wrong close", 0, 0);
    endtask

    task automatic t_restart();
        access(0, 13'h0000, 0); access(0, 13'h1555, 0); access(0, 13'h0AAA, 0);
        access(0, 13'h0000, 0);
        access(0, 13'h1555, 0); access(0, 13'h0AAA, 0); access(0, 13'h1FFF, 0);
        access(0, 13'h10F0, 0); access(0, 13'h0F0F, 0);
        counts("R6 restart at step two", 1, 0);
    endtask

    task automatic t_busy();
        access(0, 13'h0000, 0); access(0, 13'h1555, 0);
        access(0, 13'h0333, 1); access(1, 13'h0444, 1);
        access(0, 13'h0AAA, 0); access(0, 13'h1FFF, 0); access(0, 13'h10F0, 0);
        access(0, 13'h0F0F, 1);
        check("R7 busy close ignored", save_pulse, 0);
        access(0, 13'h0F0F, 0);
        counts("R7 busy ignored", 1, 0);
    endtask

    task automatic t_idle_after();
        prefix(); access(0, 13'h0F0F, 0);
        access(0, 13'h0F0F, 0); access(0, 13'h0F0E, 0);
        counts("R8 idle after command", 1, 0);
        prefix(); access(0, 13'h0F0E, 0);
        counts("R8 second full sequence", 0, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_save();
        t_reload_gaps();
        t_write_abort();
        t_stray_read();
        t_restart();
        t_busy();
        t_idle_after();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule